// File: doc/BRIEF.md
# Supervisor-Aware Program Counter Sequencer

This block holds the instruction address of a 32-bit load/store processor and works out the address that follows it. Each cycle it forms three candidates from the current address: the sequential address (PC+4), a PC-relative branch target taken from the low half of the instruction word, and a jump target taken from a register operand. An already-decoded 3-bit select code chooses among these candidates and two fixed trap vectors. The chosen address is loaded into the PC on a rising clock edge when the advance strobe is high.

The top bit of the PC is a privilege flag. Sequential and branch addresses keep it as it is. A jump can clear it but can never set it. Only a synchronous reset, the illegal-instruction vector and the interrupt vector can put it at one. Every loaded address is word aligned. The block moves no data stream, so there is no valid/ready handshake and no back-pressure: the select code, the operands, the reset and the advance strobe are plain control inputs, sampled at each rising edge.

Top module: `pc_sequencer`

## Requirements
- R1: `nsel` picks the next address. 3'b000 gives PC+4, 3'b001 gives the branch target, 3'b010 gives the jump target, 3'b011 gives the trap vector 0x80000004 and 3'b100 gives the interrupt vector 0x80000008. The codes 3'b101, 3'b110 and 3'b111 also give 0x80000004.
- R2: `pc_plus4_o` is {PC[31], PC[30:0]+4}. The carry out of bit 30 is dropped, so PC 0x7FFFFFFC gives 0x00000000.
- R3: `branch_o` is PC+4 plus the 16-bit `offset_i` sign-extended to 32 bits and shifted left by two. Bit 31 of the result is then replaced by PC[31]. From PC 0x7FFFFFF0 with offset +4, the result is 0x00000004.
- R4: The jump target is {PC[31] & jreg_i[31], jreg_i[30:0]}.
- R5: Reset is synchronous and has priority over `step_en`. A rising edge with `rst` high loads 0x80000000, and the PC stays at that value for as long as `rst` is high.
- R6: A rising edge with `rst` low and `step_en` low leaves `pc_o` unchanged.
- R7: `next_pc_o` is combinational and shows the selected address before the edge. A rising edge with `rst` low and `step_en` high loads that value into `pc_o`.
- R8: Bits [1:0] of `next_pc_o`, and of every value loaded into the PC, are 2'b00. A jump to 0x90000011 in supervisor mode loads 0x90000010.
- R9: When PC[31] changes from 0 to 1 with `rst` low, the new PC is 0x80000004 or 0x80000008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to 0x80000000 |
| step_en | input | 1 | Advance strobe: the PC loads only when this is high |
| nsel | input | 3 | Next-address select code |
| offset_i | input | 16 | Low half of the instruction word (word offset for branches) |
| jreg_i | input | 32 | Register operand used as the jump target |
| pc_o | output | 32 | Current instruction address |
| pc_plus4_o | output | 32 | Sequential address with the privilege bit kept |
| branch_o | output | 32 | Branch target with the privilege bit kept |
| next_pc_o | output | 32 | Selected, aligned next address |

## Verification
The assertions assume that `rst` is high at the first clock edge, so that the PC starts from a known value. They also assume that `nsel`, `offset_i`, `jreg_i` and `step_en` carry no X or Z during any cycle with `rst` low. The stimulus meets both conditions. It holds `rst` high from time zero, and it always drives every input with definite values, changing them only at the falling edge. The privilege checks are exercised with register operands that have bit 31 set while the block is in user mode, and with branches and sequential steps that carry across the 0x7FFFFFFF/0x80000000 boundary.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int XLEN  = 32;
  localparam int OFS_W = 16;
  localparam int MSB   = XLEN - 1;

  // Fixed addresses; top bit set marks supervisor mode.
  localparam logic [XLEN-1:0] VEC_RESET = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] VEC_TRAP  = VEC_RESET | XLEN'(4);
  localparam logic [XLEN-1:0] VEC_IRQ   = VEC_RESET | XLEN'(8);

  typedef enum logic [2:0] {
    NS_SEQ    = 3'b000,
    NS_BRANCH = 3'b001,
    NS_JUMP   = 3'b010,
    NS_TRAP   = 3'b011,
    NS_IRQ    = 3'b100
  } nsel_e;
endpackage

// File: rtl/pcseq_targets.sv
module pcseq_targets
  import pcseq_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int OW = OFS_W
) (
  input  logic [W-1:0]  pc,
  input  logic [OW-1:0] offset,
  output logic [W-1:0]  seq,
  output logic [W-1:0]  branch
);
  localparam int HI = W - 1;

  logic [W-1:0] ofs_bytes;
  logic [W-1:0] br_sum;

  // sign extension and x4 are pure wiring
  assign ofs_bytes = {{(W-OW-2){offset[OW-1]}}, offset, 2'b00};
  assign seq       = {pc[HI], pc[HI-1:0] + (HI)'(4)};
  assign br_sum    = seq + ofs_bytes;
  assign branch    = {pc[HI], br_sum[HI-1:0]};
endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
  import pcseq_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [2:0]   sel,
  input  logic         sup,
  input  logic [W-1:0] seq,
  input  logic [W-1:0] branch,
  input  logic [W-1:0] jreg,
  output logic [W-1:0] next_pc
);
  localparam int HI = W - 1;

  logic [W-1:0] jump_tgt;
  logic [W-1:0] picked;

  // a jump may drop supervisor mode but never raise it
  assign jump_tgt = {sup & jreg[HI], jreg[HI-1:0]};

  always_comb begin
    case (sel)
      NS_SEQ:    picked = seq;
      NS_BRANCH: picked = branch;
      NS_JUMP:   picked = jump_tgt;
      NS_IRQ:    picked = VEC_IRQ;
      default:   picked = VEC_TRAP;
    endcase
  end

  assign next_pc = {picked[HI:2], 2'b00};
endmodule

// File: rtl/pcseq_state.sv
module pcseq_state
  import pcseq_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= VEC_RESET;
    else if (en) q <= d;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [2:0]       nsel,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [XLEN-1:0]  jreg_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  pc_plus4_o,
  output logic [XLEN-1:0]  branch_o,
  output logic [XLEN-1:0]  next_pc_o
);
  logic [XLEN-1:0] pc_q;

  pcseq_targets #(.W(XLEN), .OW(OFS_W)) u_tgt (
    .pc     (pc_q),
    .offset (offset_i),
    .seq    (pc_plus4_o),
    .branch (branch_o)
  );

  pcseq_select #(.W(XLEN)) u_sel (
    .sel     (nsel),
    .sup     (pc_q[MSB]),
    .seq     (pc_plus4_o),
    .branch  (branch_o),
    .jreg    (jreg_i),
    .next_pc (next_pc_o)
  );

  pcseq_state #(.W(XLEN)) u_pc (
    .clk (clk),
    .rst (rst),
    .en  (step_en),
    .d   (next_pc_o),
    .q   (pc_q)
  );

  assign pc_o = pc_q;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker
  import pcseq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            step_en,
  input logic [2:0]      nsel,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] pc_plus4_o,
  input logic [XLEN-1:0] branch_o,
  input logic [XLEN-1:0] next_pc_o
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R5: the edge after reset was seen high shows the reset vector
  a_r5_reset_vector: assert property (@(posedge clk)
    rst_q |-> (pc_o == VEC_RESET));

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pc_o));

  // R7
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (pc_o == $past(next_pc_o)));

  // R8
  a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
    (pc_o[1:0] == 2'b00) && (next_pc_o[1:0] == 2'b00));

  // R2 and R3: the privilege bit rides along unchanged
  a_r3_keep_sup: assert property (@(posedge clk) disable iff (rst)
    (pc_plus4_o[MSB] == pc_o[MSB]) && (branch_o[MSB] == pc_o[MSB]));

  // R4: a jump from user mode stays in user mode
  a_r4_jump_no_raise: assert property (@(posedge clk) disable iff (rst)
    (nsel == NS_JUMP && !pc_o[MSB]) |-> !next_pc_o[MSB]);

  // R9
  a_r9_sup_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(pc_o[MSB]) |-> (pc_o == VEC_TRAP || pc_o == VEC_IRQ));
endmodule

bind pc_sequencer pcseq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_en    (step_en),
  .nsel       (nsel),
  .pc_o       (pc_o),
  .pc_plus4_o (pc_plus4_o),
  .branch_o   (branch_o),
  .next_pc_o  (next_pc_o)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [2:0]  nsel = 3'b000;
  logic [15:0] offset_i = 16'h0;
  logic [31:0] jreg_i = 32'h0;
  logic [31:0] pc_o, pc_plus4_o, branch_o, next_pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_pc;
  bit          m_valid = 0;

  always #5 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst(rst), .step_en(step_en), .nsel(nsel),
    .offset_i(offset_i), .jreg_i(jreg_i), .pc_o(pc_o),
    .pc_plus4_o(pc_plus4_o), .branch_o(branch_o), .next_pc_o(next_pc_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks the combinational outputs
  // and queues the PC expected after the coming edge.
  task automatic drive(input bit r, input bit en, input logic [2:0] s,
                       input logic [15:0] off, input logic [31:0] jr, input string tag);
    logic [31:0] e4, ebr, ejt, eraw, enx, bsum;
    @(negedge clk);
    rst = r; step_en = en; nsel = s; offset_i = off; jreg_i = jr;
    #1;
    e4   = {m_pc[31], m_pc[30:0] + 31'd4};
    bsum = e4 + {{14{off[15]}}, off, 2'b00};
    ebr  = {m_pc[31], bsum[30:0]};
    ejt  = {m_pc[31] & jr[31], jr[30:0]};
    case (s)
      3'b000:  eraw = e4;
      3'b001:  eraw = ebr;
      3'b010:  eraw = ejt;
      3'b100:  eraw = 32'h8000_0008;
      default: eraw = 32'h8000_0004;
    endcase
    enx = {eraw[31:2], 2'b00};
    if (m_valid) begin
      check("R2 pc_plus4_o", pc_plus4_o, e4);
      check("R3 branch_o", branch_o, ebr);
      check("R7 next_pc_o", next_pc_o, enx);
    end
    if (r) m_pc = 32'h8000_0000;
    else if (en) m_pc = enx;
    m_valid = 1;
    exp_q.push_back(m_pc);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares the PC after each edge with the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, pc_o, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    drive(1, 0, 3'b000, 16'h0, 32'h0, "R5 reset with strobe low");
    drive(1, 1, 3'b010, 16'h0, 32'h1234_5678, "R5 reset beats strobe");
    drive(0, 1, 3'b000, 16'h0, 32'h0, "R1 sequential step");
    drive(0, 0, 3'b001, 16'h0040, 32'h0, "R6 hold when strobe low");
    drive(0, 1, 3'b001, 16'hFFFE, 32'h0, "R3 backward branch");
    drive(0, 1, 3'b010, 16'h0, 32'h9000_0011, "R8 aligned supervisor jump");
    drive(0, 1, 3'b010, 16'h0, 32'h1000_0012, "R4 jump clears supervisor");
    drive(0, 1, 3'b010, 16'h0, 32'hF000_0000, "R4 user jump cannot set bit 31");
    drive(0, 0, 3'b010, 16'h0, 32'hFFFF_FFFF, "R6 hold ignores jump");
    drive(0, 1, 3'b010, 16'h0, 32'h7FFF_FFF0, "R1 jump near boundary");
    drive(0, 1, 3'b001, 16'h0004, 32'h0, "R3 branch carry keeps user mode");
    drive(0, 1, 3'b010, 16'h0, 32'h7FFF_FFFC, "R1 jump to top word");
    drive(0, 1, 3'b000, 16'h0, 32'h0, "R2 sequential wrap keeps user mode");
    drive(0, 1, 3'b011, 16'h0, 32'h0, "R9 trap vector sets supervisor");
    drive(0, 1, 3'b010, 16'h0, 32'h0000_0100, "R4 leave supervisor");
    drive(0, 1, 3'b100, 16'h0, 32'h0, "R9 interrupt vector sets supervisor");
    drive(0, 1, 3'b101, 16'h0, 32'h0, "R1 code 101 traps");
    drive(0, 1, 3'b110, 16'h0, 32'h0, "R1 code 110 traps");
    drive(0, 1, 3'b111, 16'h0, 32'h0, "R1 code 111 traps");
    drive(0, 1, 3'b001, 16'h7FFF, 32'h0, "R3 large forward branch");
    drive(1, 1, 3'b000, 16'h0, 32'h0, "R5 reset mid-run");
    drive(1, 0, 3'b000, 16'h0, 32'h0, "R5 reset held");
    drive(0, 1, 3'b000, 16'h0, 32'h0, "R7 step after reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule